// File: doc/BRIEF.md
# Edge Interrupt and Wakeup Detector

This block is the interrupt front end for a bank of general-purpose pins. Each pin level is first passed through a synchronizer. The block then compares the current synchronized level with the level from one cycle earlier, so it sees only changes of level. Software sets four independent enable masks. Two of them choose which rising and falling edges become pending interrupts. The other two choose which rising and falling edges raise a wakeup request.

Pending interrupts collect in a status register, one bit per pin. Writing a 1 to a bit of the clear register clears that pin's bit. A single interrupt line to the parent controller is high while any status bit is set. A registered wakeup line pulses for one cycle for each cycle in which an edge passes a wake mask. The block detects edges only and has no level-triggered mode.

Writes use one data word and a 3-bit select. The same select codes drive a combinational read port, which returns the masks and the status.

Top module: `edge_irq_wake`

## Requirements
- R1: After reset, all four masks and the status register read 0, `irq_o` is 0 and `wake_o` is 0.
- R2: A write with `wr_sel_i` = 0, 1, 2 or 3 loads the whole data word into the rising-interrupt, falling-interrupt, rising-wake or falling-wake mask. The write leaves the other masks unchanged, and the mask reads back on `rd_data_o` with the same select code.
- R3: A 0-to-1 change on `pin_i[i]` while the rising-interrupt mask bit i is set makes status bit i read 1 after the third rising clock edge that follows the change, and not before.
- R4: A 1-to-0 change on `pin_i[i]` while the falling-interrupt mask bit i is set makes status bit i read 1 with the same three-edge latency.
- R5: A level change whose edge type is not enabled in the interrupt masks, and a pin held at a steady level, leave the status bit at 0.
- R6: When both interrupt mask bits of a pin are set, a rising edge and a falling edge each set that pin's status bit.
- R7: A write with `wr_sel_i` = 4 clears every status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R8: If a clear and a newly detected enabled edge reach the same status bit in the same cycle, the bit ends up set.
- R9: `irq_o` is 1 exactly while at least one status bit is set.
- R10: An edge that passes a wake mask drives `wake_o` high for one cycle, three rising clock edges after the pin change. The wake masks never set status bits.
- R11: Status bits of different pins are set and cleared independently, including edges on several pins in the same cycle.
- R12: `rd_sel_i` = 4 returns the status register. Unused select codes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Raw pin levels, asynchronous to clk_i |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 3 | Write target: 0 rise-irq, 1 fall-irq, 2 rise-wake, 3 fall-wake mask, 4 clear |
| wr_data_i | input | NUM_PINS | Write data |
| rd_sel_i | input | 3 | Read select: 0..3 masks, 4 status |
| rd_data_o | output | NUM_PINS | Read data |
| status_o | output | NUM_PINS | Pending edge status |
| irq_o | output | 1 | Parent interrupt request |
| wake_o | output | 1 | Wakeup request pulse |

## Verification
The bench checks the exact latency of the status bit by looking one edge early as well as on time. A design with a missing or extra register stage would show the bit too soon or too late. It drives a clear into the same cycle as a new edge on that pin, where a design that gives the clear priority would lose the event. It clears with partial data words and checks the untouched bits, which would catch a design that clears the whole register. It also shows that edge types not enabled in the masks, steady levels and the wake masks all leave the status unchanged. A design that detects levels, or merges the wake path into the interrupt path, would fail those checks.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int SEL_W = 3;
  localparam int NUM_MASKS = 4;

  typedef enum logic [SEL_W-1:0] {
    SEL_RISE_IRQ  = 3'd0,
    SEL_FALL_IRQ  = 3'd1,
    SEL_RISE_WAKE = 3'd2,
    SEL_FALL_WAKE = 3'd3,
    SEL_CLEAR     = 3'd4
  } sel_e;
endpackage

// File: rtl/eiw_sync.sv
module eiw_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eiw_edge.sv
module eiw_edge #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/eiw_mask_bank.sv
module eiw_mask_bank
  import edge_irq_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [SEL_W-1:0]                wr_sel_i,
  input  logic [WIDTH-1:0]                wr_data_i,
  output logic [NUM_MASKS-1:0][WIDTH-1:0] mask_o
);
  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_mask
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)  mask_o[g] <= '0;
      else if (hit) mask_o[g] <= wr_data_i;
  end
endmodule

// File: rtl/eiw_status.sv
module eiw_status #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] status_o
);
  // set applied after clear: set wins on collision
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_o <= '0;
    else         status_o <= (status_o & ~clr_i) | set_i;
endmodule

// File: rtl/edge_irq_wake.sv
module edge_irq_wake
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                wr_en_i,
  input  logic [2:0]          wr_sel_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic [2:0]          rd_sel_i,
  output logic [NUM_PINS-1:0] rd_data_o,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o,
  output logic                wake_o
);
  logic [NUM_PINS-1:0] lvl, rise, fall, set_vec, clr_vec, wake_hit;
  logic [NUM_MASKS-1:0][NUM_PINS-1:0] masks;
  logic wake_q;

  eiw_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(lvl)
  );

  eiw_edge #(.WIDTH(NUM_PINS)) u_edge (
    .clk_i, .rst_ni, .lvl_i(lvl), .rise_o(rise), .fall_o(fall)
  );

  eiw_mask_bank #(.WIDTH(NUM_PINS)) u_masks (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .mask_o(masks)
  );

  assign set_vec  = (rise & masks[SEL_RISE_IRQ])  | (fall & masks[SEL_FALL_IRQ]);
  assign wake_hit = (rise & masks[SEL_RISE_WAKE]) | (fall & masks[SEL_FALL_WAKE]);
  assign clr_vec  = (wr_en_i && wr_sel_i == SEL_CLEAR) ? wr_data_i : '0;

  eiw_status #(.WIDTH(NUM_PINS)) u_status (
    .clk_i, .rst_ni, .set_i(set_vec), .clr_i(clr_vec), .status_o
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) wake_q <= 1'b0;
    else         wake_q <= |wake_hit;

  assign wake_o = wake_q;
  assign irq_o  = |status_o;

  always_comb begin
    unique case (rd_sel_i)
      SEL_RISE_IRQ:  rd_data_o = masks[SEL_RISE_IRQ];
      SEL_FALL_IRQ:  rd_data_o = masks[SEL_FALL_IRQ];
      SEL_RISE_WAKE: rd_data_o = masks[SEL_RISE_WAKE];
      SEL_FALL_WAKE: rd_data_o = masks[SEL_FALL_WAKE];
      SEL_CLEAR:     rd_data_o = status_o;
      default:       rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/edge_irq_wake_chk.sv
module edge_irq_wake_chk
  import edge_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               wr_en_i,
  input logic [2:0]                         wr_sel_i,
  input logic [NUM_PINS-1:0]                status_o,
  input logic                               irq_o,
  input logic                               wake_o,
  input logic [NUM_PINS-1:0]                set_vec,
  input logic [NUM_PINS-1:0]                clr_vec,
  input logic [NUM_PINS-1:0]                wake_hit,
  input logic [NUM_MASKS-1:0][NUM_PINS-1:0] masks
);
  AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~status_o & ~$past(clr_vec)) == '0)); // R7

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((status_o & $past(set_vec)) == $past(set_vec))); // R8

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & ~$past(status_o) & ~$past(set_vec)) == '0)); // R5

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(set_vec) != '0)); // R9

  AST_WAKE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ($past(wake_hit) != '0)); // R10

  for (genvar g = 0; g < NUM_MASKS; g++) begin : g_hold
    AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_sel_i == SEL_W'(g)) |=> $stable(masks[g])); // R2
  end
endmodule

bind edge_irq_wake edge_irq_wake_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .status_o(status_o), .irq_o(irq_o), .wake_o(wake_o), .set_vec(set_vec),
  .clr_vec(clr_vec), .wake_hit(wake_hit), .masks(masks)
);

// File: tb/edge_irq_wake_bench.sv
`timescale 1ns/1ps
module edge_irq_wake_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pins = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_sel = '0;
  logic [N-1:0] wr_data = '0;
  logic [2:0]   rd_sel = '0;
  logic [N-1:0] rd_data, status;
  logic         irq, wake;
  int n_tests = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  edge_irq_wake u_edge_irq_wake (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .status_o(status), .irq_o(irq), .wake_o(wake)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] sel, logic [N-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [N-1:0] data);
    rd_sel = sel;
    #0.1;
    data = rd_data;
  endtask

  task automatic clear_all();
    for (int s = 0; s < 4; s++) wr(3'(s), '0);
    wr(3'd4, '1);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(3'(s), v);
      chk("R1 mask", v, '0);
    end
    chk("R1 status", status, '0);
    chk("R1 irq", N'(irq), '0);
    chk("R1 wake", N'(wake), '0);
  endtask

  task automatic t_masks();
    logic [N-1:0] v;
    wr(3'd0, 32'h1111_0001);
    wr(3'd1, 32'h2222_0002);
    wr(3'd2, 32'h4444_0004);
    wr(3'd3, 32'h8888_0008);
    rd(3'd0, v); chk("R2 rise irq mask", v, 32'h1111_0001);
    rd(3'd1, v); chk("R2 fall irq mask", v, 32'h2222_0002);
    rd(3'd2, v); chk("R2 rise wake mask", v, 32'h4444_0004);
    rd(3'd3, v); chk("R2 fall wake mask", v, 32'h8888_0008);
    rd(3'd6, v); chk("R12 unused select", v, '0);
    clear_all();
  endtask

  task automatic t_rise();
    logic [N-1:0] v;
    wr(3'd0, 32'h0000_0088);
    pins[3] = 1'b1;
    tick(2);
    chk("R3 not before third edge", status, '0);
    tick();
    chk("R3 rising edge status", status, 32'h0000_0008);
    chk("R9 irq high", N'(irq), 1);
    rd(3'd4, v); chk("R12 status read", v, 32'h0000_0008);
    pins[3] = 1'b0;
    tick(4);
    chk("R5 fall not enabled", status, 32'h0000_0008);
    clear_all();
  endtask

  task automatic t_fall();
    wr(3'd1, 32'h0000_0020);
    pins[5] = 1'b1;
    tick(4);
    chk("R5 rise not enabled", status, '0);
    pins[5] = 1'b0;
    tick(3);
    chk("R4 falling edge status", status, 32'h0000_0020);
    clear_all();
  endtask

  task automatic t_both();
    wr(3'd0, 32'h0000_0400);
    wr(3'd1, 32'h0000_0400);
    pins[10] = 1'b1;
    tick(3);
    chk("R6 rise with both", status, 32'h0000_0400);
    wr(3'd4, 32'h0000_0400);
    chk("R6 cleared", status, '0);
    pins[10] = 1'b0;
    tick(3);
    chk("R6 fall with both", status, 32'h0000_0400);
    clear_all();
  endtask

  task automatic t_clear();
    wr(3'd0, 32'h0000_0028);
    pins[3] = 1'b1; pins[5] = 1'b1;
    tick(3);
    chk("R11 two pins", status, 32'h0000_0028);
    wr(3'd4, 32'h0000_0008);
    chk("R7 partial clear", status, 32'h0000_0020);
    chk("R9 irq still high", N'(irq), 1);
    wr(3'd4, 32'h0000_0000);
    chk("R7 zero write no effect", status, 32'h0000_0020);
    wr(3'd4, 32'h0000_0020);
    chk("R7 cleared", status, '0);
    chk("R9 irq low", N'(irq), 0);
    tick(3);
    chk("R5 steady level no set", status, '0);
    pins[3] = 1'b0; pins[5] = 1'b0;
    tick(3);
    clear_all();
  endtask

  task automatic t_set_wins();
    wr(3'd0, 32'h0000_0003);
    pins[1] = 1'b1;
    tick(3);
    pins[0] = 1'b1;
    tick(2);
    wr(3'd4, 32'h0000_0003);
    chk("R8 set wins over clear", status, 32'h0000_0001);
    pins[0] = 1'b0; pins[1] = 1'b0;
    tick(3);
    clear_all();
  endtask

  task automatic t_wake();
    wr(3'd2, 32'h0010_0000);
    wr(3'd3, 32'h0020_0000);
    pins[20] = 1'b1;
    tick(2);
    chk("R10 wake not early", N'(wake), 0);
    tick();
    chk("R10 wake pulse rise", N'(wake), 1);
    tick();
    chk("R10 wake one cycle", N'(wake), 0);
    chk("R10 no status from wake", status, '0);
    pins[21] = 1'b1;
    tick(4);
    chk("R10 fall-wake ignores rise", N'(wake), 0);
    pins[21] = 1'b0;
    tick(3);
    chk("R10 wake pulse fall", N'(wake), 1);
    chk("R10 irq low", N'(irq), 0);
    pins[20] = 1'b0;
    tick(3);
    clear_all();
  endtask

  task automatic t_multi();
    wr(3'd0, 32'h8000_0001);
    pins[0] = 1'b1; pins[31] = 1'b1; pins[15] = 1'b1;
    tick(3);
    chk("R11 edge pins 0 and 31", status, 32'h8000_0001);
    wr(3'd4, 32'h8000_0000);
    chk("R11 independent clear", status, 32'h0000_0001);
    pins = '0;
    tick(3);
    clear_all();
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_masks();
    t_rise();
    t_fall();
    t_both();
    t_clear();
    t_set_wins();
    t_wake();
    t_multi();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule